// File: doc/BRIEF.md
# GPIO Port with Per-Pin Peripheral Override

This block is one eight-pin slice of a general-purpose I/O port. It holds three software registers: the pin direction, the output value, and a port-wide switch that turns off all pull-ups. It turns them into pad controls: the output value, the output enable and the pull-up enable. It also reads the pads back through a two-stage synchronizer. A small register interface writes these registers and reads them back.

Each pin has its own override layer, so that a peripheral can take the pin over without software changing the registers. A peripheral can separately take control of the pull-up, the driver enable, the driven value and the digital-input enable. It can also ask for the stored output bit to be inverted. The raw pad level goes straight to the peripherals, ahead of the synchronizer. The digital input is gated off in sleep unless a peripheral keeps it enabled.

Top module: `gpio_ovr_port`

## Requirements
- R1: After reset the direction, output and pull-up-disable registers are 0. pad_oe, pad_pu and pad_out are all 0, and so is every register read.
- R2: Register select bus_addr: 1 = direction, 2 = output value, 3 = control (bit 0 = global pull-up disable, other bits read 0), 0 = synchronized pin readback. A write takes effect at the next rising clock edge. bus_rdata shows the selected register combinationally.
- R3: With the pull-up override enable low, pad_pu[i] is 1 only when direction bit = 0, output bit = 1 and global pull-up disable = 0.
- R4: With the pull-up override enable high and the driver off, pad_pu[i] equals the override value, whatever the direction, output and pull-up-disable bits are.
- R5: pad_pu[i] is 0 whenever pad_oe[i] is 1, even if an override asks for the pull-up.
- R6: pad_oe[i] equals the direction override value when the direction override enable is high. Otherwise it equals the direction register bit.
- R7: When pad_oe[i] is 1, pad_out[i] is the value override if the value override enable is high, and the output register bit otherwise. When pad_oe[i] is 0, pad_out[i] is 0.
- R8: Writing to address 0 inverts each output bit whose write-data bit is 1, at the next clock. A high ovr_tog[i] at a clock edge inverts output bit i. If it falls in the same cycle as a write to address 2, the written value is stored with that bit inverted.
- R9: The digital input of pin i is enabled by ovr_die_val[i] when ovr_die_en[i] is high, and by !sleep_i otherwise. The address-0 readback equals pad_in gated by that enable, as it stood two clock edges earlier, so a disabled input reads 0.
- R10: per_din equals pad_in combinationally, whatever the sleep state and the input-enable overrides.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register select |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register |
| sleep_i | input | 1 | Device sleep flag |
| pad_in | input | 8 | Level at the pads |
| pad_out | output | 8 | Value driven to the pads |
| pad_oe | output | 8 | Pad driver enable |
| pad_pu | output | 8 | Pad pull-up enable |
| per_din | output | 8 | Unsynchronized pad level for peripherals |
| ovr_pu_en | input | 8 | Pull-up override enable per pin |
| ovr_pu_val | input | 8 | Pull-up override value per pin |
| ovr_dir_en | input | 8 | Driver-enable override enable per pin |
| ovr_dir_val | input | 8 | Driver-enable override value per pin |
| ovr_val_en | input | 8 | Output-value override enable per pin |
| ovr_val_val | input | 8 | Output-value override value per pin |
| ovr_tog | input | 8 | Output-bit invert request per pin |
| ovr_die_en | input | 8 | Input-enable override enable per pin |
| ovr_die_val | input | 8 | Input-enable override value per pin |

## Verification
A software write to the output register and a peripheral invert request can fall on the same clock edge. The bench provokes this by raising ovr_tog on two bits during the very cycle that writes a new value to address 2. It then reads back the written value with exactly those two bits flipped. A second collision is between a pull-up override and a driver override on one pin. This case is judged at the pads: the pull-up must stay off while the pin drives.

// File: rtl/gpio_ovr_pkg.sv
package gpio_ovr_pkg;

    localparam int unsigned REG_AW = 2;

    typedef enum logic [REG_AW-1:0] {
        REG_PIN = 2'd0,
        REG_DIR = 2'd1,
        REG_OUT = 2'd2,
        REG_CTL = 2'd3
    } reg_sel_e;

    localparam int unsigned CTL_PUD_BIT = 0;

endpackage

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux (
    input  logic dir_i,
    input  logic out_i,
    input  logic pud_i,
    input  logic sleep_i,
    input  logic pu_en_i,
    input  logic pu_val_i,
    input  logic dir_en_i,
    input  logic dir_val_i,
    input  logic val_en_i,
    input  logic val_val_i,
    input  logic die_en_i,
    input  logic die_val_i,
    output logic oe_o,
    output logic pad_o,
    output logic pu_o,
    output logic die_o
);

    logic oe_sel;
    logic val_sel;
    logic pu_dflt;
    logic pu_sel;

    always_comb begin
        oe_sel  = dir_en_i ? dir_val_i : dir_i;
        val_sel = val_en_i ? val_val_i : out_i;
        pu_dflt = ~dir_i & out_i & ~pud_i;
        pu_sel  = pu_en_i ? pu_val_i : pu_dflt;
        oe_o    = oe_sel;
        pad_o   = oe_sel & val_sel;
        pu_o    = pu_sel & ~oe_sel;
        die_o   = die_en_i ? die_val_i : ~sleep_i;
    end

endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int unsigned W      = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [STAGES-1:0][W-1:0] stg_d;
    logic [STAGES-1:0][W-1:0] stg_q;

    always_comb begin
        stg_d[0] = d_i;
        for (int s = 1; s < STAGES; s++) begin
            stg_d[s] = stg_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_q <= '0;
        end else begin
            stg_q <= stg_d;
        end
    end

    assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/gpio_ovr_port.sv
module gpio_ovr_port
    import gpio_ovr_pkg::*;
#(
    parameter int unsigned NPIN        = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [NPIN-1:0]   bus_wdata,
    output logic [NPIN-1:0]   bus_rdata,
    input  logic              sleep_i,
    input  logic [NPIN-1:0]   pad_in,
    output logic [NPIN-1:0]   pad_out,
    output logic [NPIN-1:0]   pad_oe,
    output logic [NPIN-1:0]   pad_pu,
    output logic [NPIN-1:0]   per_din,
    input  logic [NPIN-1:0]   ovr_pu_en,
    input  logic [NPIN-1:0]   ovr_pu_val,
    input  logic [NPIN-1:0]   ovr_dir_en,
    input  logic [NPIN-1:0]   ovr_dir_val,
    input  logic [NPIN-1:0]   ovr_val_en,
    input  logic [NPIN-1:0]   ovr_val_val,
    input  logic [NPIN-1:0]   ovr_tog,
    input  logic [NPIN-1:0]   ovr_die_en,
    input  logic [NPIN-1:0]   ovr_die_val
);

    typedef struct packed {
        logic [NPIN-1:0] dir;
        logic [NPIN-1:0] out;
        logic            pud;
    } port_state_t;

    port_state_t     st_d;
    port_state_t     st_q;
    logic [NPIN-1:0] die_vec;
    logic [NPIN-1:0] in_gated;
    logic [NPIN-1:0] pin_q;
    logic            wr_pin;
    logic            wr_out;
    logic [NPIN-1:0] out_base;
    logic [NPIN-1:0] tog_mask;

    // next-state process
    always_comb begin
        st_d     = st_q;
        wr_pin   = bus_wr && (bus_addr == REG_PIN);
        wr_out   = bus_wr && (bus_addr == REG_OUT);
        out_base = wr_out ? bus_wdata : st_q.out;
        tog_mask = ovr_tog | (wr_pin ? bus_wdata : '0);
        st_d.out = out_base ^ tog_mask;
        if (bus_wr && (bus_addr == REG_DIR)) begin
            st_d.dir = bus_wdata;
        end
        if (bus_wr && (bus_addr == REG_CTL)) begin
            st_d.pud = bus_wdata[CTL_PUD_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // read mux
    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            REG_PIN: bus_rdata = pin_q;
            REG_DIR: bus_rdata = st_q.dir;
            REG_OUT: bus_rdata = st_q.out;
            REG_CTL: bus_rdata[CTL_PUD_BIT] = st_q.pud;
            default: bus_rdata = '0;
        endcase
    end

    // per-pin override muxes
    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        gpio_pin_mux u_mux (
            .dir_i     (st_q.dir[i]),
            .out_i     (st_q.out[i]),
            .pud_i     (st_q.pud),
            .sleep_i   (sleep_i),
            .pu_en_i   (ovr_pu_en[i]),
            .pu_val_i  (ovr_pu_val[i]),
            .dir_en_i  (ovr_dir_en[i]),
            .dir_val_i (ovr_dir_val[i]),
            .val_en_i  (ovr_val_en[i]),
            .val_val_i (ovr_val_val[i]),
            .die_en_i  (ovr_die_en[i]),
            .die_val_i (ovr_die_val[i]),
            .oe_o      (pad_oe[i]),
            .pad_o     (pad_out[i]),
            .pu_o      (pad_pu[i]),
            .die_o     (die_vec[i])
        );
    end

    assign in_gated = pad_in & die_vec;
    assign per_din  = pad_in;

    gpio_sync #(
        .W      (NPIN),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (in_gated),
        .q_o   (pin_q)
    );

    // checks
    AST_PU_OFF_WHEN_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_pu & pad_oe) == '0); // R5

    AST_IDLE_PAD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_out & ~pad_oe) == '0); // R7

    AST_DIR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == REG_DIR) |=> (st_q.dir == $past(bus_wdata))); // R2

    AST_PIN_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == REG_PIN && ovr_tog == '0)
        |=> (st_q.out == ($past(st_q.out) ^ $past(bus_wdata)))); // R8

    AST_SLEEP_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sleep_i) && $past(ovr_die_en) == '0 && sleep_i && ovr_die_en == '0)
        |=> (pin_q == '0)); // R9

endmodule

// File: tb/tb_gpio_ovr_port.sv
`timescale 1ns/1ps
module tb_gpio_ovr_port;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       sleep_i = 1'b0;
    logic [7:0] pad_in = '0;
    logic [7:0] pad_out, pad_oe, pad_pu, per_din;
    logic [7:0] ovr_pu_en = '0, ovr_pu_val = '0, ovr_dir_en = '0, ovr_dir_val = '0;
    logic [7:0] ovr_val_en = '0, ovr_val_val = '0, ovr_tog = '0;
    logic [7:0] ovr_die_en = '0, ovr_die_val = '0;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    gpio_ovr_port dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sleep_i(sleep_i),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu),
        .per_din(per_din), .ovr_pu_en(ovr_pu_en), .ovr_pu_val(ovr_pu_val),
        .ovr_dir_en(ovr_dir_en), .ovr_dir_val(ovr_dir_val),
        .ovr_val_en(ovr_val_en), .ovr_val_val(ovr_val_val), .ovr_tog(ovr_tog),
        .ovr_die_en(ovr_die_en), .ovr_die_val(ovr_die_val)
    );

    // fields: [11]dir [10]out [9]pud [8]pu_en [7]pu_val [6]dir_en [5]dir_val
    //         [4]val_en [3]val_val | expected [2]oe [1]pu [0]pad_out
    localparam int NVEC = 12;
    localparam logic [11:0] VEC [NVEC] = '{
        12'b010_00_00_00_010, // R3 default pull-up
        12'b011_00_00_00_000, // R3 global disable
        12'b000_00_00_00_000, // R3 out low
        12'b110_00_00_00_101, // R6 R7 R5 driven high
        12'b001_11_00_00_010, // R4 override on
        12'b010_10_00_00_000, // R4 override off
        12'b000_11_11_00_100, // R5 driver override beats pull-up
        12'b100_00_10_00_000, // R6 override disables driver
        12'b100_00_00_11_101, // R7 value override high
        12'b110_00_00_10_100, // R7 value override low
        12'b010_00_00_11_010, // R7 no drive, pad stays 0
        12'b000_00_11_00_100  // R6 override enables driver
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic finish_run;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
            finish_run();
        end
    end

    initial begin
        logic [7:0] rd;
        repeat (3) @(negedge clk);
        #1;
        check("R1 pad_oe", pad_oe, 8'h00);
        check("R1 pad_pu", pad_pu, 8'h00);
        check("R1 pad_out", pad_out, 8'h00);
        for (int a = 0; a < 4; a++) begin
            bus_read(a[1:0], rd);
            check("R1 read", rd, 8'h00);
        end
        rst_n = 1'b1;

        // table walk
        for (int v = 0; v < NVEC; v++) begin
            bus_write(2'd1, {8{VEC[v][11]}});
            bus_write(2'd2, {8{VEC[v][10]}});
            bus_write(2'd3, {7'b0, VEC[v][9]});
            ovr_pu_en   = {8{VEC[v][8]}};
            ovr_pu_val  = {8{VEC[v][7]}};
            ovr_dir_en  = {8{VEC[v][6]}};
            ovr_dir_val = {8{VEC[v][5]}};
            ovr_val_en  = {8{VEC[v][4]}};
            ovr_val_val = {8{VEC[v][3]}};
            #1;
            check("R6 vec oe", pad_oe, {8{VEC[v][2]}});
            check("R3/R4/R5 vec pu", pad_pu, {8{VEC[v][1]}});
            check("R7 vec out", pad_out, {8{VEC[v][0]}});
        end
        ovr_pu_en = '0; ovr_pu_val = '0; ovr_dir_en = '0; ovr_dir_val = '0;
        ovr_val_en = '0; ovr_val_val = '0;

        // R2 register map
        bus_write(2'd1, 8'hA5);
        bus_read(2'd1, rd);
        check("R2 dir read", rd, 8'hA5);
        bus_write(2'd3, 8'hFF);
        bus_read(2'd3, rd);
        check("R2 ctl read", rd, 8'h01);
        bus_write(2'd3, 8'h00);
        bus_write(2'd1, 8'h00);

        // R8 toggles
        bus_write(2'd2, 8'h0F);
        bus_write(2'd0, 8'h3C);
        bus_read(2'd2, rd);
        check("R8 sw toggle", rd, 8'h33);
        @(negedge clk); ovr_tog = 8'h01;
        @(negedge clk); ovr_tog = 8'h00;
        bus_read(2'd2, rd);
        check("R8 periph toggle", rd, 8'h32);
        @(negedge clk);
        bus_addr = 2'd2; bus_wdata = 8'hF0; bus_wr = 1'b1; ovr_tog = 8'h81;
        @(negedge clk);
        bus_wr = 1'b0; ovr_tog = 8'h00;
        bus_read(2'd2, rd);
        check("R8 write+toggle same cycle", rd, 8'h71);

        // R9 readback latency and gating, R10 raw path
        pad_in = 8'h5A;
        bus_read(2'd0, rd);
        check("R10 raw input", per_din, 8'h5A);
        @(negedge clk);
        bus_read(2'd0, rd);
        check("R9 one edge old", rd, 8'h00);
        @(negedge clk);
        bus_read(2'd0, rd);
        check("R9 two edges", rd, 8'h5A);
        sleep_i = 1'b1;
        repeat (2) @(negedge clk);
        bus_read(2'd0, rd);
        check("R9 sleep gated", rd, 8'h00);
        check("R10 raw in sleep", per_din, 8'h5A);
        ovr_die_en = 8'h0F; ovr_die_val = 8'h0F;
        repeat (2) @(negedge clk);
        bus_read(2'd0, rd);
        check("R9 override keeps input", rd, 8'h0A);
        sleep_i = 1'b0; ovr_die_en = 8'hFF; ovr_die_val = 8'h00;
        repeat (2) @(negedge clk);
        bus_read(2'd0, rd);
        check("R9 override disables", rd, 8'h00);
        check("R10 raw with override", per_din, 8'h5A);

        done = 1'b1;
        finish_run();
    end

endmodule